// File: doc/BRIEF.md
# Pseudo-SRAM Deep Power-Down Sequencer

This block drives the second chip enable (the power-down pin) of an asynchronous pseudo-SRAM. It also gates the first chip enable that the access controller drives. It steps the memory through its power-up wait and its wake-up hold. It then takes the memory into deep power-down and back out, and it keeps every minimum delay the memory needs as a count of clock cycles. Each delay is set by a parameter.

The host gives a supply-good level, a sleep request and a wake request. The access controller reports when it is idle, and it receives a `ready` level. Until `ready` is high, the block holds the memory's first chip enable inactive, whatever the access controller drives. The memory loses its contents in deep power-down, so the block raises a sticky `data_lost` flag on every wake. The host clears this flag.

Top module: `psram_dpd_seq`

## Requirements
- R1: After reset, `mem_ce2` is 0, `mem_ce1_n` is 1, `ready` is 0 and `data_lost` is 0.
- R2: `mem_ce2` first rises only after `pwr_good` has been sampled high on PWR_WAIT_CYC consecutive clock edges. Any low sample of `pwr_good` before that restarts the count.
- R3: Each time `mem_ce2` rises, `ready` stays low for exactly WAKE_HOLD_CYC cycles and then goes high.
- R4: While `ready` is 0, `mem_ce1_n` is 1 whatever the value of `ctl_ce1_n`. While `ready` is 1, `mem_ce1_n` equals `ctl_ce1_n` in the same cycle.
- R5: A `sleep_req` sampled while `ready` is 1 is accepted only if `ctl_idle` is 1 on the same edge. When `ctl_idle` is 0, `ready` stays 1 and `mem_ce2` stays 1.
- R6: Once a sleep request is accepted, `ready` drops and `mem_ce1_n` is held at 1. `mem_ce2` then stays at 1 for ENTER_CYC cycles before it falls, so CE1 is already high when CE2 falls.
- R7: Once `mem_ce2` falls for deep power-down, it stays low for at least DPD_MIN_CYC cycles. A `wake_req` pulse that arrives earlier is remembered, and the block exits when the minimum has elapsed. A later pulse causes the exit on the edge that samples it.
- R8: `data_lost` is set on every exit from deep power-down and stays at 1 until `clr_lost` is sampled high. If a set and a clear fall on the same edge, the set wins.
- R9: A `wake_req` while `ready` is 1 has no effect: `ready` and `mem_ce2` stay at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_good | input | 1 | Supply has reached its valid level |
| sleep_req | input | 1 | Request to enter deep power-down |
| wake_req | input | 1 | Request to leave deep power-down |
| ctl_idle | input | 1 | Access controller has no access in flight |
| ctl_ce1_n | input | 1 | Chip enable from the access controller, active low |
| clr_lost | input | 1 | Host clears the data-lost flag |
| mem_ce1_n | output | 1 | Gated chip enable to the memory, active low |
| mem_ce2 | output | 1 | Power-down pin to the memory, low for deep power-down |
| ready | output | 1 | Memory may be accessed |
| data_lost | output | 1 | Memory contents must be treated as invalid |

## Verification
Two events can fall on the same edge: the flag is set by an exit from deep power-down, and the host clears it. The bench drives `clr_lost` in the cycle in which it also drives the wake pulse, after the minimum low time has passed, so that both are sampled on the exit edge. The flag must then read 1 at the first observation with `mem_ce2` high. A second coincidence is a wake pulse sampled on the very edge on which the minimum low time expires. The bench judges it by an exact count of low cycles.

// File: rtl/psram_dpd_seq.sv
module psram_dpd_seq #(
  parameter int unsigned PWR_WAIT_CYC  = 6000,
  parameter int unsigned WAKE_HOLD_CYC = 60000,
  parameter int unsigned DPD_MIN_CYC   = 2000000,
  parameter int unsigned ENTER_CYC     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic sleep_req,
  input  logic wake_req,
  input  logic ctl_idle,
  input  logic ctl_ce1_n,
  input  logic clr_lost,
  output logic mem_ce1_n,
  output logic mem_ce2,
  output logic ready,
  output logic data_lost
);
  localparam int unsigned MAX_AB  = (PWR_WAIT_CYC > WAKE_HOLD_CYC) ? PWR_WAIT_CYC : WAKE_HOLD_CYC;
  localparam int unsigned MAX_CD  = (DPD_MIN_CYC > ENTER_CYC) ? DPD_MIN_CYC : ENTER_CYC;
  localparam int unsigned MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int          CW      = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {
    POWER_UP_WAIT, INIT_HOLD, READY, DPD_ENTER, DPD_HOLD, WAKE_HOLD
  } state_t;

  state_t        state, state_nx;
  logic [CW-1:0] cnt, limit;
  logic          cnt_done, wake_pend, in_dpd, exit_dpd;

  always_comb begin
    case (state)
      POWER_UP_WAIT:        limit = CW'(PWR_WAIT_CYC - 1);
      INIT_HOLD, WAKE_HOLD: limit = CW'(WAKE_HOLD_CYC - 1);
      DPD_ENTER:            limit = CW'(ENTER_CYC - 1);
      DPD_HOLD:             limit = CW'(DPD_MIN_CYC - 1);
      default:              limit = '0;
    endcase
  end

  assign cnt_done = (cnt == limit);
  assign in_dpd   = (state == DPD_ENTER) || (state == DPD_HOLD);

  always_comb begin
    state_nx = state;
    case (state)
      POWER_UP_WAIT:        if (pwr_good && cnt_done) state_nx = INIT_HOLD;
      INIT_HOLD, WAKE_HOLD: if (cnt_done) state_nx = READY;
      READY:                if (sleep_req && ctl_idle) state_nx = DPD_ENTER;
      DPD_ENTER:            if (cnt_done) state_nx = DPD_HOLD;
      DPD_HOLD:             if (cnt_done && (wake_pend || wake_req)) state_nx = WAKE_HOLD;
      default:              state_nx = POWER_UP_WAIT;
    endcase
  end

  assign exit_dpd = (state == DPD_HOLD) && (state_nx == WAKE_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= POWER_UP_WAIT;
      cnt       <= '0;
      wake_pend <= 1'b0;
      data_lost <= 1'b0;
    end else begin
      state <= state_nx;
      if (state_nx != state)                        cnt <= '0;
      else if (state == POWER_UP_WAIT && !pwr_good) cnt <= '0;
      else if (!cnt_done)                           cnt <= cnt + CW'(1);
      wake_pend <= in_dpd && !exit_dpd && (wake_pend || wake_req);
      if (exit_dpd)      data_lost <= 1'b1;
      else if (clr_lost) data_lost <= 1'b0;
    end
  end

  assign ready     = (state == READY);
  assign mem_ce2   = !((state == POWER_UP_WAIT) || (state == DPD_HOLD));
  assign mem_ce1_n = ready ? ctl_ce1_n : 1'b1;
endmodule

// File: rtl/psram_dpd_seq_chk.sv
module psram_dpd_seq_chk #(
  parameter int unsigned PWR_WAIT_CYC  = 6000,
  parameter int unsigned WAKE_HOLD_CYC = 60000,
  parameter int unsigned DPD_MIN_CYC   = 2000000
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_good,
  input logic sleep_req,
  input logic ctl_idle,
  input logic mem_ce1_n,
  input logic mem_ce2,
  input logic ready,
  input logic data_lost
);
  int unsigned pg_cnt, lo_cnt, hold_cnt;
  logic        up_done;

  function automatic int unsigned sat_inc(input int unsigned v);
    return (v == 32'hFFFF_FFFF) ? v : v + 1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_cnt   <= 0;
      lo_cnt   <= 0;
      hold_cnt <= 0;
      up_done  <= 1'b0;
    end else begin
      pg_cnt   <= pwr_good ? sat_inc(pg_cnt) : 0;
      lo_cnt   <= mem_ce2 ? 0 : sat_inc(lo_cnt);
      hold_cnt <= (mem_ce2 && !ready) ? sat_inc(hold_cnt) : 0;
      if (mem_ce2) up_done <= 1'b1;
    end
  end

  a_r2_pwr_wait: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_ce2) && !up_done) |-> (pg_cnt >= PWR_WAIT_CYC));

  a_r3_hold_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (hold_cnt >= WAKE_HOLD_CYC));

  a_r4_ready_needs_ce2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> mem_ce2);

  a_r5_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(sleep_req && ctl_idle));

  a_r6_ce1_high_at_ce2_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce2) |-> (mem_ce1_n && $past(mem_ce1_n)));

  a_r7_min_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_ce2) && up_done) |-> (lo_cnt >= DPD_MIN_CYC));

  a_r8_lost_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_lost) |-> $rose(mem_ce2));
endmodule

bind psram_dpd_seq psram_dpd_seq_chk #(
  .PWR_WAIT_CYC (PWR_WAIT_CYC),
  .WAKE_HOLD_CYC(WAKE_HOLD_CYC),
  .DPD_MIN_CYC  (DPD_MIN_CYC)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwr_good (pwr_good),
  .sleep_req(sleep_req),
  .ctl_idle (ctl_idle),
  .mem_ce1_n(mem_ce1_n),
  .mem_ce2  (mem_ce2),
  .ready    (ready),
  .data_lost(data_lost)
);

// File: tb/psram_dpd_seq_tb_top.sv
module psram_dpd_seq_tb_top;
  localparam int P_PWR   = 8;
  localparam int P_WAKE  = 12;
  localparam int P_DPD   = 20;
  localparam int P_ENTER = 2;

  // each row: wake pulse index in the low phase, expected low cycles, clear on exit edge
  localparam int RUN_TAB [0:5][0:2] = '{
    '{0, 20, 0}, '{5, 20, 0}, '{18, 20, 0},
    '{19, 20, 1}, '{20, 21, 1}, '{30, 31, 0}
  };

  logic clk = 1'b0;
  logic rst_n, pwr_good, sleep_req, wake_req, ctl_idle, ctl_ce1_n, clr_lost;
  logic mem_ce1_n, mem_ce2, ready, data_lost;
  int   errs = 0;
  int   total = 0;

  always #2.5 clk = ~clk;

  psram_dpd_seq #(
    .PWR_WAIT_CYC(P_PWR), .WAKE_HOLD_CYC(P_WAKE),
    .DPD_MIN_CYC(P_DPD), .ENTER_CYC(P_ENTER)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .sleep_req(sleep_req),
    .wake_req(wake_req), .ctl_idle(ctl_idle), .ctl_ce1_n(ctl_ce1_n),
    .clr_lost(clr_lost), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
    .ready(ready), .data_lost(data_lost)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic dpd_run(input int k, input int exp_low, input bit clr_same);
    int n;
    int bad;
    ctl_ce1_n = 1'b0; ctl_idle = 1'b1; sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    chk(!ready && mem_ce2, "R5 accepted when idle", {ready, mem_ce2}, 1);
    n = 0; bad = 0;
    while (mem_ce2 && n < 100) begin
      if (!mem_ce1_n) bad++;
      n++;
      @(negedge clk);
    end
    chk(n == P_ENTER && bad == 0, "R6 enter cycles with CE1 high", n, P_ENTER);
    n = 0;
    while (!mem_ce2 && n < 1000) begin
      wake_req = (n == k);
      clr_lost = clr_same && (n == k);
      @(negedge clk);
      n++;
    end
    wake_req = 1'b0; clr_lost = 1'b0;
    chk(n == exp_low, "R7 low cycles", n, exp_low);
    chk(data_lost == 1'b1, "R8 set on exit", data_lost, 1);
    n = 0; bad = 0;
    while (!ready && n < 1000) begin
      if (!mem_ce1_n) bad++;
      n++;
      @(negedge clk);
    end
    chk(n == P_WAKE, "R3 wake hold", n, P_WAKE);
    chk(bad == 0, "R4 CE1 forced high", bad, 0);
    repeat (3) @(negedge clk);
    chk(data_lost == 1'b1, "R8 sticky", data_lost, 1);
    clr_lost = 1'b1;
    @(negedge clk);
    clr_lost = 1'b0;
    chk(data_lost == 1'b0, "R8 cleared", data_lost, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

  initial begin
    int n;
    int bad;
    rst_n = 1'b0; pwr_good = 1'b0; sleep_req = 1'b0; wake_req = 1'b0;
    ctl_idle = 1'b0; ctl_ce1_n = 1'b0; clr_lost = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_ce2, "R1 ce2 low", mem_ce2, 0);
    chk(mem_ce1_n, "R1 ce1_n high", mem_ce1_n, 1);
    chk(!ready, "R1 not ready", ready, 0);
    chk(!data_lost, "R1 data_lost low", data_lost, 0);

    pwr_good = 1'b1;
    repeat (5) @(negedge clk);
    pwr_good = 1'b0;
    @(negedge clk);
    chk(!mem_ce2, "R2 short pwr_good ignored", mem_ce2, 0);
    pwr_good = 1'b1;
    n = 0;
    while (!mem_ce2 && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(n == P_PWR, "R2 power-up wait", n, P_PWR);
    n = 0; bad = 0;
    while (!ready && n < 1000) begin
      if (!mem_ce1_n) bad++;
      n++;
      @(negedge clk);
    end
    chk(n == P_WAKE, "R3 initial hold", n, P_WAKE);
    chk(bad == 0, "R4 CE1 forced high in init", bad, 0);

    ctl_ce1_n = 1'b1; #1;
    chk(mem_ce1_n == 1'b1, "R4 pass high", mem_ce1_n, 1);
    ctl_ce1_n = 1'b0; #1;
    chk(mem_ce1_n == 1'b0, "R4 pass low", mem_ce1_n, 0);
    @(negedge clk);

    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    @(negedge clk);
    chk(ready && mem_ce2, "R9 wake in ready ignored", {ready, mem_ce2}, 3);

    ctl_idle = 1'b0; sleep_req = 1'b1;
    repeat (3) @(negedge clk);
    sleep_req = 1'b0;
    chk(ready && mem_ce2, "R5 busy sleep ignored", {ready, mem_ce2}, 3);
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      dpd_run(RUN_TAB[i][0], RUN_TAB[i][1], RUN_TAB[i][2] != 0);
    end

    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule